// File: doc/BRIEF.md
# Memory Pattern Test Engine

This block tests an external memory at full bus speed. It acts as a burst master toward a memory controller and is driven by software through a small register port. Software chooses one of eight data patterns, a start address and a beat count, then starts a fill pass or a check pass. A fill pass writes the generated pattern over the range in bursts. A check pass reads the range back one burst at a time and compares every returned beat with the pattern, which is regenerated in hardware.

After a pass, software reads three values: how many beats matched, how many beats were compared, and how many clock cycles the pass was busy. A check passes when the first two are equal. The cycle count lets software derive throughput. An identity word, a version word and a configuration word give the data width in bytes and the burst length, so a driver can find them.

The memory side uses a wait-request handshake for commands and write data, and a read-valid strobe for returned data. The parameters are DATA_BYTES, BURST_LEN, ADDR_W and CNT_W. DATA_BYTES must be a power of two and at least 16. CNT_W and ADDR_W must be no more than 32.

Top module: `memtest_engine`

## Requirements
- R1: After reset, mem_rd and mem_wr are low, and the status, match, checked and cycle registers all read 0.
- R2: Register 7 reads 0x3E3C8EC8 and register 8 reads 10003 (decimal). Register 9 reads DATA_BYTES in bits [15:0] and BURST_LEN in bits [31:16].
- R3: The beat index k starts at 0 for each pass. Mode 0 gives all zeros and mode 1 gives all ones. Mode 2 sets only bit k mod W, and mode 3 clears only that bit, where W is the data width in bits. Mode 4 gives 0x55 bytes on even k and 0xAA bytes on odd k. Modes 5, 6 and 7 place k, truncated or zero-extended to 8, 32 and 128 bits, in every lane of that width.
- R4: Register 2 holds the byte start address and register 3 holds the beat count N. Burst j is issued at address start + j*BURST_LEN*DATA_BYTES, with a burst count of min(remaining beats, BURST_LEN).
- R5: While mem_wr is high and mem_wait is high, write data, address and burst count hold, and mem_wr stays high. Data advances only on accepted beats.
- R6: A check pass has at most one read burst outstanding. A new read command is raised only after every beat of the previous burst has returned, and beats are compared in return order.
- R7: Register 4 counts matching beats and register 5 counts compared beats of the last check pass. Both are 0 after a fill pass, and the match count never exceeds the checked count.
- R8: Register 6 equals the number of clock cycles in which busy was high during the last pass.
- R9: Writing register 0 with bit0=1 starts a pass. Bit1 selects the direction (1 = check, 0 = fill) and bits [4:2] select the mode. Register 1 holds busy in bit0 and done in bit1. A start clears done and the counters. Done stays set until the next start, and busy and done are never both set.
- R10: A start written while busy is ignored. The running pass continues unchanged.
- R11: A pass with N = 0 makes no memory access. It ends with done set, zero counts and a cycle count of 1.
- R12: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 4 | Register index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Registered read data for the index of the previous cycle |
| mem_addr | output | ADDR_W | Byte address of the current burst |
| mem_burst | output | clog2(BURST_LEN+1) | Beats in the current burst |
| mem_wr | output | 1 | Write request, one beat per accepted cycle |
| mem_rd | output | 1 | Read burst command |
| mem_wdata | output | DATA_BYTES*8 | Write data |
| mem_wait | input | 1 | Controller stall; a request is accepted when this is low |
| mem_rdata | input | DATA_BYTES*8 | Returned read data |
| mem_rvalid | input | 1 | Returned read beat is valid |

## Verification
Two events can fall in the same cycle and are checked on purpose. In a check pass, the last beat of a burst returns in the same cycle the engine must decide whether to raise the next read command. In a fill pass, the last write beat of a burst is accepted in the same cycle the burst address advances, often just after a stall.

The memory model in the bench provokes both. It raises wait-request in a pseudo-random pattern and returns read beats with random gaps, using burst lengths that do not divide the beat count. It judges the results in two ways:
- It flags any read command raised while beats are still pending.
- It compares every burst address and burst count, and every accepted write beat, against values the bench computes from the requirements.

// File: rtl/memtest_pkg.sv
`timescale 1ns/1ps
package memtest_pkg;
  typedef enum logic [2:0] {
    PAT_ZERO, PAT_ONES, PAT_WALK1, PAT_WALK0,
    PAT_ALT, PAT_CNT8, PAT_CNT32, PAT_CNT128
  } pat_mode_e;

  typedef enum logic [2:0] {ST_IDLE, ST_WR, ST_RCMD, ST_RDAT, ST_FIN} seq_st_e;

  localparam logic [3:0] RA_CTRL    = 4'd0;
  localparam logic [3:0] RA_STAT    = 4'd1;
  localparam logic [3:0] RA_BASE    = 4'd2;
  localparam logic [3:0] RA_WORDS   = 4'd3;
  localparam logic [3:0] RA_MATCH   = 4'd4;
  localparam logic [3:0] RA_CHECKED = 4'd5;
  localparam logic [3:0] RA_CYCLES  = 4'd6;
  localparam logic [3:0] RA_IDENT   = 4'd7;
  localparam logic [3:0] RA_VER     = 4'd8;
  localparam logic [3:0] RA_CONFIG  = 4'd9;

  localparam logic [31:0] IDENT_VAL   = 32'h3E3C_8EC8;
  localparam logic [31:0] VERSION_VAL = 32'd10003;
endpackage

// File: rtl/memtest_patgen.sv
`timescale 1ns/1ps
// Pattern source (R3): data word for beat index idx under the given mode.
module memtest_patgen
  import memtest_pkg::*;
#(
  parameter int DW = 512,
  parameter int IW = 32
) (
  input  pat_mode_e         mode,
  input  logic [IW-1:0]     idx,
  output logic [DW-1:0]     pat
);
  localparam int PW = $clog2(DW);

  logic [DW-1:0] c8, c32, c128, walk;

  for (genvar g = 0; g < DW/8; g++) begin : g_c8
    assign c8[g*8 +: 8] = idx[7:0];
  end
  for (genvar g = 0; g < DW/32; g++) begin : g_c32
    assign c32[g*32 +: 32] = 32'(idx);
  end
  for (genvar g = 0; g < DW/128; g++) begin : g_c128
    assign c128[g*128 +: 128] = 128'(idx);
  end

  assign walk = {{(DW-1){1'b0}}, 1'b1} << idx[PW-1:0];

  always_comb begin
    case (mode)
      PAT_ZERO:   pat = '0;
      PAT_ONES:   pat = '1;
      PAT_WALK1:  pat = walk;
      PAT_WALK0:  pat = ~walk;
      PAT_ALT:    pat = {(DW/8){idx[0] ? 8'hAA : 8'h55}};
      PAT_CNT8:   pat = c8;
      PAT_CNT32:  pat = c32;
      default:    pat = c128;
    endcase
  end
endmodule

// File: rtl/memtest_seq.sv
`timescale 1ns/1ps
// Pass sequencer: burst writes, one-at-a-time burst reads, compare and counters.
module memtest_seq
  import memtest_pkg::*;
#(
  parameter int DATA_BYTES = 64,
  parameter int BURST_LEN  = 8,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic                              dir_in,
  input  pat_mode_e                         mode_in,
  input  logic [ADDR_W-1:0]                 base_in,
  input  logic [CNT_W-1:0]                  words_in,
  output logic [ADDR_W-1:0]                 mem_addr,
  output logic [$clog2(BURST_LEN+1)-1:0]    mem_burst,
  output logic                              mem_wr,
  output logic                              mem_rd,
  output logic [DATA_BYTES*8-1:0]           mem_wdata,
  input  logic                              mem_wait,
  input  logic [DATA_BYTES*8-1:0]           mem_rdata,
  input  logic                              mem_rvalid,
  output logic                              busy,
  output logic                              done,
  output logic [CNT_W-1:0]                  match_cnt,
  output logic [CNT_W-1:0]                  chk_cnt,
  output logic [CNT_W-1:0]                  cyc_cnt
);
  localparam int DW  = DATA_BYTES * 8;
  localparam int BCW = $clog2(BURST_LEN + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_LEN * DATA_BYTES);

  seq_st_e         st;
  pat_mode_e       mode_q, pmode;
  logic [CNT_W-1:0] beat, left, pidx;
  logic [BCW-1:0]  bleft;
  logic [DW-1:0]   pat;
  logic            go, last_b, last_all;

  function automatic logic [BCW-1:0] bsize(input logic [CNT_W-1:0] n);
    return (n > CNT_W'(BURST_LEN)) ? BCW'(BURST_LEN) : BCW'(n);
  endfunction

  always_comb begin
    go       = start && (st == ST_IDLE);              // R10: ignored unless idle
    pmode    = go ? mode_in : mode_q;
    pidx     = go ? '0 : ((st == ST_WR) ? beat + CNT_W'(1) : beat);
    last_b   = (bleft == BCW'(1));
    last_all = (left == CNT_W'(1));
  end

  memtest_patgen #(.DW(DW), .IW(CNT_W)) u_pat (.mode(pmode), .idx(pidx), .pat(pat));

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; mode_q <= PAT_ZERO; beat <= '0; left <= '0; bleft <= '0;
      mem_addr <= '0; mem_burst <= '0; mem_wr <= 1'b0; mem_rd <= 1'b0; mem_wdata <= '0;
      done <= 1'b0; match_cnt <= '0; chk_cnt <= '0; cyc_cnt <= '0;
    end else begin
      if (st != ST_IDLE) cyc_cnt <= cyc_cnt + CNT_W'(1);   // R8
      case (st)
        ST_IDLE: if (go) begin
          mode_q <= mode_in; beat <= '0; left <= words_in; bleft <= bsize(words_in);
          mem_addr <= base_in; mem_burst <= bsize(words_in); mem_wdata <= pat;
          done <= 1'b0; match_cnt <= '0; chk_cnt <= '0; cyc_cnt <= '0;
          if (words_in == '0) st <= ST_FIN;                 // R11
          else if (dir_in) begin st <= ST_RCMD; mem_rd <= 1'b1; end
          else begin st <= ST_WR; mem_wr <= 1'b1; end
        end
        ST_WR: if (!mem_wait) begin                         // R5
          beat <= beat + CNT_W'(1); left <= left - CNT_W'(1); mem_wdata <= pat;
          if (last_b) begin
            if (last_all) begin mem_wr <= 1'b0; st <= ST_FIN; end
            else begin
              mem_addr  <= mem_addr + STEP;                 // R4
              mem_burst <= bsize(left - CNT_W'(1));
              bleft     <= bsize(left - CNT_W'(1));
            end
          end else bleft <= bleft - BCW'(1);
        end
        ST_RCMD: if (!mem_wait) begin mem_rd <= 1'b0; st <= ST_RDAT; end
        ST_RDAT: if (mem_rvalid) begin                      // R6, R7
          chk_cnt <= chk_cnt + CNT_W'(1);
          if (mem_rdata == pat) match_cnt <= match_cnt + CNT_W'(1);
          beat <= beat + CNT_W'(1); left <= left - CNT_W'(1);
          if (last_b) begin
            if (last_all) st <= ST_FIN;
            else begin
              mem_addr  <= mem_addr + STEP;
              mem_burst <= bsize(left - CNT_W'(1));
              bleft     <= bsize(left - CNT_W'(1));
              mem_rd    <= 1'b1; st <= ST_RCMD;
            end
          end else bleft <= bleft - BCW'(1);
        end
        ST_FIN: begin st <= ST_IDLE; done <= 1'b1; end     // R9
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: a stalled write beat holds everything.
  a_r5_wr_hold: assert property (@(posedge clk) disable iff (rst)
    mem_wr && mem_wait |=> mem_wr && $stable(mem_wdata) && $stable(mem_addr) && $stable(mem_burst));
  // R6: a stalled read command holds.
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (rst)
    mem_rd && mem_wait |=> mem_rd && $stable(mem_addr) && $stable(mem_burst));
  // R4: a request always carries a legal burst count.
  a_r4_burst_range: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> (mem_burst != '0) && (mem_burst <= BCW'(BURST_LEN)));
  // R12
  a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));
  // R7
  a_r7_match_le_chk: assert property (@(posedge clk) disable iff (rst) match_cnt <= chk_cnt);
  a_r7_count_on_valid: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RDAT) && !mem_rvalid |=> $stable(chk_cnt) && $stable(match_cnt));
  // R9
  a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (rst) !(busy && done));
endmodule

// File: rtl/memtest_csr.sv
`timescale 1ns/1ps
// Software register port: configuration, start decode, registered read mux.
module memtest_csr
  import memtest_pkg::*;
#(
  parameter int DATA_BYTES = 64,
  parameter int BURST_LEN  = 8,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               csr_wr,
  input  logic [3:0]         csr_addr,
  input  logic [31:0]        csr_wdata,
  output logic [31:0]        csr_rdata,
  output logic               start,
  output logic               dir,
  output pat_mode_e          mode,
  output logic [ADDR_W-1:0]  base,
  output logic [CNT_W-1:0]   words,
  input  logic               busy,
  input  logic               done,
  input  logic [CNT_W-1:0]   match_cnt,
  input  logic [CNT_W-1:0]   chk_cnt,
  input  logic [CNT_W-1:0]   cyc_cnt
);
  assign start = csr_wr && (csr_addr == RA_CTRL) && csr_wdata[0];   // R9
  assign dir   = csr_wdata[1];
  assign mode  = pat_mode_e'(csr_wdata[4:2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0; words <= '0; csr_rdata <= '0;
    end else begin
      if (csr_wr && csr_addr == RA_BASE)  base  <= ADDR_W'(csr_wdata);
      if (csr_wr && csr_addr == RA_WORDS) words <= CNT_W'(csr_wdata);
      case (csr_addr)
        RA_STAT:    csr_rdata <= {30'b0, done, busy};
        RA_BASE:    csr_rdata <= 32'(base);
        RA_WORDS:   csr_rdata <= 32'(words);
        RA_MATCH:   csr_rdata <= 32'(match_cnt);
        RA_CHECKED: csr_rdata <= 32'(chk_cnt);
        RA_CYCLES:  csr_rdata <= 32'(cyc_cnt);
        RA_IDENT:   csr_rdata <= IDENT_VAL;
        RA_VER:     csr_rdata <= VERSION_VAL;
        RA_CONFIG:  csr_rdata <= {16'(BURST_LEN), 16'(DATA_BYTES)};   // R2
        default:    csr_rdata <= '0;
      endcase
    end
  end

  // R2: the identity index reads the fixed word one cycle later.
  a_r2_ident: assert property (@(posedge clk) disable iff (rst)
    csr_addr == RA_IDENT |=> csr_rdata == IDENT_VAL);
endmodule

// File: rtl/memtest_engine.sv
`timescale 1ns/1ps
module memtest_engine
  import memtest_pkg::*;
#(
  parameter int DATA_BYTES = 64,
  parameter int BURST_LEN  = 8,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            csr_wr,
  input  logic [3:0]                      csr_addr,
  input  logic [31:0]                     csr_wdata,
  output logic [31:0]                     csr_rdata,
  output logic [ADDR_W-1:0]               mem_addr,
  output logic [$clog2(BURST_LEN+1)-1:0]  mem_burst,
  output logic                            mem_wr,
  output logic                            mem_rd,
  output logic [DATA_BYTES*8-1:0]         mem_wdata,
  input  logic                            mem_wait,
  input  logic [DATA_BYTES*8-1:0]         mem_rdata,
  input  logic                            mem_rvalid
);
  logic             start, dir, busy, done;
  pat_mode_e        mode;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0] words, match_cnt, chk_cnt, cyc_cnt;

  memtest_csr #(.DATA_BYTES(DATA_BYTES), .BURST_LEN(BURST_LEN), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_csr (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .start(start), .dir(dir), .mode(mode), .base(base), .words(words),
    .busy(busy), .done(done), .match_cnt(match_cnt), .chk_cnt(chk_cnt), .cyc_cnt(cyc_cnt));

  memtest_seq #(.DATA_BYTES(DATA_BYTES), .BURST_LEN(BURST_LEN), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .dir_in(dir), .mode_in(mode), .base_in(base),
    .words_in(words), .mem_addr(mem_addr), .mem_burst(mem_burst), .mem_wr(mem_wr),
    .mem_rd(mem_rd), .mem_wdata(mem_wdata), .mem_wait(mem_wait), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .busy(busy), .done(done), .match_cnt(match_cnt),
    .chk_cnt(chk_cnt), .cyc_cnt(cyc_cnt));
endmodule

// File: tb/sim_memtest_engine.sv
`timescale 1ns/1ps
module sim_memtest_engine;
  localparam int DB = 64, BL = 4, W = 512, MN = 64;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        csr_wr = 1'b0;
  logic [3:0]  csr_addr = 4'd0;
  logic [31:0] csr_wdata = 32'd0;
  logic [31:0] csr_rdata;
  logic [31:0] mem_addr;
  logic [2:0]  mem_burst;
  logic        mem_wr, mem_rd;
  logic [W-1:0] mem_wdata;
  logic        mem_wait = 1'b0, mem_rvalid = 1'b0;
  logic [W-1:0] mem_rdata = '0;

  memtest_engine #(.DATA_BYTES(DB), .BURST_LEN(BL)) u0 (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .mem_addr(mem_addr), .mem_burst(mem_burst), .mem_wr(mem_wr),
    .mem_rd(mem_rd), .mem_wdata(mem_wdata), .mem_wait(mem_wait), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid));

  int n_chk = 0, n_bad = 0, wd = 0;
  // model bookkeeping
  logic [W-1:0] mem [MN];
  logic [15:0] lfsr = 16'hACE1;
  int exp_mode = 0, exp_base = 0, exp_words = 0;
  int nburst = 0, wk = 0, wbad = 0, wleft = 0, widx = 0, rd_pend = 0, rd_idx = 0;
  int n_wr = 0, n_rdcmd = 0, rd_overlap = 0, bad_burst = 0;
  int busy_n = 0;
  logic [31:0] first_stat, rv;

  // Reference pattern written bit by bit from the R3 definitions.
  function automatic logic [W-1:0] ref_pat(input int m, input int k);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      case (m)
        0: r[i] = 1'b0;
        1: r[i] = 1'b1;
        2: r[i] = (i == k % W);
        3: r[i] = (i != k % W);
        4: r[i] = (k % 2 == 0) ? (i % 2 == 0) : (i % 2 == 1);
        5: r[i] = 1'((k >> (i % 8)) & 1);
        6: r[i] = 1'((k >> (i % 32)) & 1);
        default: r[i] = (i % 128 < 32) ? 1'((k >> (i % 128)) & 1) : 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic bit burst_ok(input logic [31:0] a, input int bc);
    int rem, ebc;
    rem = exp_words - nburst * BL;
    ebc = (rem > BL) ? BL : rem;
    return (a == 32'((exp_base + nburst * BL) * DB)) && (bc == ebc);
  endfunction

  // Memory model: random stalls, gapped read returns, per-beat write checks.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rd_pend > 0 && lfsr[3]) begin
      mem_rvalid = 1'b1; mem_rdata = mem[rd_idx]; rd_idx = (rd_idx + 1) % MN; rd_pend--;
    end else begin
      mem_rvalid = 1'b0; mem_rdata = '0;
    end
    mem_wait = !rst && lfsr[0] && lfsr[5];
    if (!rst && mem_wr && !mem_wait) begin
      if (wleft == 0) begin
        if (!burst_ok(mem_addr, int'(mem_burst))) bad_burst++;
        wleft = int'(mem_burst); widx = int'(mem_addr[11:6]); nburst++;
      end
      mem[widx] = mem_wdata;
      if (mem_wdata !== ref_pat(exp_mode, wk)) wbad++;
      wk++; widx = (widx + 1) % MN; wleft--; n_wr++;
    end
    if (!rst && mem_rd) begin
      if (rd_pend != 0) rd_overlap++;
      if (!mem_wait) begin
        if (!burst_ok(mem_addr, int'(mem_burst))) bad_burst++;
        rd_pend = int'(mem_burst); rd_idx = int'(mem_addr[11:6]); nburst++; n_rdcmd++;
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", wd);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_wr = 1'b0;
  endtask

  task automatic csr_read(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); csr_addr = a;
    @(negedge clk); v = csr_rdata;
  endtask

  task automatic setup(input int m, input int b, input int w);
    exp_mode = m; exp_base = b; exp_words = w;
    nburst = 0; wk = 0; wbad = 0; wleft = 0; n_wr = 0; n_rdcmd = 0; rd_overlap = 0; bad_burst = 0;
    csr_write(4'd2, 32'(b * DB));
    csr_write(4'd3, 32'(w));
  endtask

  task automatic kick(input int m, input int d);
    csr_write(4'd0, 32'((m << 2) | (d << 1) | 1));
    csr_addr = 4'd1;
  endtask

  task automatic wait_done();
    busy_n = 0;
    @(negedge clk); first_stat = csr_rdata;
    while (!csr_rdata[1]) begin
      if (csr_rdata[0]) busy_n++;
      @(negedge clk);
    end
  endtask

  task automatic run_pass(input int m, input int d, input int b, input int w);
    setup(m, b, w); kick(m, d); wait_done();
  endtask

  // mode, base beat, beat count, expected match count of the check pass
  localparam int VEC [8][4] = '{
    '{0, 0, 5, 5}, '{1, 3, 8, 8}, '{2, 10, 13, 13}, '{3, 0, 16, 16},
    '{4, 20, 7, 7}, '{5, 1, 20, 20}, '{6, 30, 9, 9}, '{7, 5, 17, 17}};

  initial begin
    for (int i = 0; i < MN; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(!mem_rd && !mem_wr, "R1 rd/wr idle", {mem_rd, mem_wr}, 0);
    csr_read(4'd1, rv); chk(rv == 0, "R1 status", rv, 0);
    csr_read(4'd4, rv); chk(rv == 0, "R1 match", rv, 0);
    csr_read(4'd5, rv); chk(rv == 0, "R1 checked", rv, 0);
    csr_read(4'd6, rv); chk(rv == 0, "R1 cycles", rv, 0);
    // R2 identity words
    csr_read(4'd7, rv); chk(rv == 32'h3E3C8EC8, "R2 ident", rv, 32'h3E3C8EC8);
    csr_read(4'd8, rv); chk(rv == 32'd10003, "R2 version", rv, 10003);
    csr_read(4'd9, rv); chk(rv == {16'(BL), 16'(DB)}, "R2 config", rv, {16'(BL), 16'(DB)});

    // Vector table: fill then check each mode
    for (int v = 0; v < 8; v++) begin
      run_pass(VEC[v][0], 0, VEC[v][1], VEC[v][2]);
      chk(wbad == 0 && wk == VEC[v][2], "R3 fill data beats", wk - wbad, VEC[v][2]);
      chk(bad_burst == 0, "R4 fill burst addr/count", bad_burst, 0);
      chk(first_stat[1:0] == 2'b01, "R9 start clears done", first_stat, 1);
      csr_read(4'd6, rv); chk(int'(rv) == busy_n, "R8 fill cycles", rv, busy_n);
      csr_read(4'd5, rv); chk(rv == 0, "R7 checked after fill", rv, 0);
      run_pass(VEC[v][0], 1, VEC[v][1], VEC[v][2]);
      chk(rd_overlap == 0, "R6 one read outstanding", rd_overlap, 0);
      chk(bad_burst == 0, "R4 read burst addr/count", bad_burst, 0);
      csr_read(4'd4, rv); chk(int'(rv) == VEC[v][3], "R7 match", rv, VEC[v][3]);
      csr_read(4'd5, rv); chk(int'(rv) == VEC[v][2], "R7 checked", rv, VEC[v][2]);
      csr_read(4'd6, rv); chk(int'(rv) == busy_n, "R8 check cycles", rv, busy_n);
    end

    // R7: a single corrupted beat costs exactly one match
    run_pass(5, 0, 40, 10);
    mem[42][100] = ~mem[42][100];
    run_pass(5, 1, 40, 10);
    csr_read(4'd4, rv); chk(rv == 9, "R7 corrupt match", rv, 9);
    csr_read(4'd5, rv); chk(rv == 10, "R7 corrupt checked", rv, 10);

    // R3/R7: check against another mode than the fill
    run_pass(1, 0, 0, 6);
    run_pass(0, 1, 0, 6);
    csr_read(4'd4, rv); chk(rv == 0, "R7 cross-mode match", rv, 0);
    csr_read(4'd5, rv); chk(rv == 6, "R7 cross-mode checked", rv, 6);

    // R3: walking one wraps at the word width (beat 512 equals beat 0)
    run_pass(2, 0, 0, 520);
    chk(wbad == 0 && wk == 520, "R3 walking wrap beats", wk - wbad, 520);
    chk(bad_burst == 0, "R4 long fill bursts", bad_burst, 0);
    run_pass(2, 1, 0, 8);
    csr_read(4'd4, rv); chk(rv == 8, "R3 walking wrap match", rv, 8);

    // R10: a start while busy is ignored
    setup(0, 40, 12); kick(0, 0);
    repeat (3) @(negedge clk);
    csr_write(4'd0, 32'((6 << 2) | (1 << 1) | 1));
    csr_addr = 4'd1;
    wait_done();
    chk(wbad == 0 && wk == 12, "R10 pass unchanged", wk - wbad, 12);
    chk(n_rdcmd == 0, "R10 no read issued", n_rdcmd, 0);
    csr_read(4'd5, rv); chk(rv == 0, "R10 checked untouched", rv, 0);

    // R11: zero beat count
    run_pass(3, 1, 5, 0);
    chk(n_wr == 0 && n_rdcmd == 0, "R11 no traffic", n_wr + n_rdcmd, 0);
    csr_read(4'd5, rv); chk(rv == 0, "R11 checked", rv, 0);
    csr_read(4'd6, rv); chk(rv == 1, "R11 cycles", rv, 1);
    // R9: done sticks while idle
    repeat (10) @(negedge clk);
    csr_read(4'd1, rv); chk(rv == 2, "R9 done sticky", rv, 2);
    // R12 is watched at every edge by the design's assertion; spot check idle here
    chk(!(mem_rd && mem_wr), "R12 rd/wr exclusive", {mem_rd, mem_wr}, 0);

    summary();
    $finish;
  end
endmodule